// File: doc/BRIEF.md
# AES Counter-Mode Memory Encryption Controller

This block holds the configuration registers and runs the sequencing engine of a counter-mode encryption accelerator. The accelerator sits on a byte-wide external memory bus. A host programs a source address, a byte length, a 128-bit key and a 128-bit initial counter through a 64-byte register window, then writes a start command. The engine then works through the region one 16-byte block at a time and writes each ciphertext block over its plaintext.

Each block passes through three phases in a fixed order. In the load phase, the engine reads 16 bytes over its own memory master port. In the operate phase, it asks an external AES-128 core for the keystream of the current counter and XORs that keystream into the buffered bytes. In the store phase, it writes the 16 result bytes back to the addresses they came from. After each block the counter steps by one, and the engine either starts the next block or returns to idle. The cipher core is outside the block and is reached through a start/done handshake.

The configuration is frozen while a job runs, so a host cannot corrupt a job that is in flight.

Top module: `ctr_crypt_engine`

## Requirements
- R1: After reset the status reads 0, the base, length and counter registers read 0, and mem_rd, mem_wr and cph_start are low.
- R2: The register map sits at window offsets from 0xff00. The 16-bit base address is at 0x02 (low byte) and 0x03. The 16-bit byte length is at 0x04 (low byte) and 0x05. The key is write-only at 0x10–0x1f. The counter is at 0x20–0x2f. For the key and the counter, offset byte 0 is the most significant byte. A read strobe returns its data on bus_rdata in the next cycle.
- R3: Offset 0x01 reads the engine status: 0 idle, 1 load, 2 operate, 3 store.
- R4: While the status is nonzero, writes to the base, length, key and counter registers are ignored.
- R5: A write to offset 0x00 with bit 0 set starts a job only when the engine is idle and the length is nonzero. Any other start write has no effect.
- R6: The load phase issues 16 single-byte reads at base+offset+i, for i rising from 0, one per cycle. Read data is taken in the cycle after each request.
- R7: The operate phase raises cph_start for exactly one cycle, with cph_ctr equal to the counter and cph_key equal to the key, and waits for cph_done. Result byte i is plaintext byte i XOR cph_ks[127-8i -: 8].
- R8: The store phase issues 16 single-byte writes to the same addresses in the same rising order, overwriting the plaintext.
- R9: A job processes ceil(length/16) blocks. The running offset grows by 16 per block, and addresses wrap modulo 2^16.
- R10: The counter increments by one after each block, wraps modulo 2^128, and the new value is visible through the counter window.
- R11: After the last block the engine returns to idle and issues no further memory or cipher requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Host bus address |
| bus_wdata | input | 8 | Host bus write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Host read data, valid the cycle after bus_rd |
| mem_addr | output | 16 | Engine memory request address |
| mem_rd | output | 1 | Engine memory read request |
| mem_wr | output | 1 | Engine memory write request |
| mem_wdata | output | 8 | Engine memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_rd |
| cph_start | output | 1 | Cipher request pulse |
| cph_ctr | output | 128 | Counter block presented to the cipher |
| cph_key | output | 128 | Key presented to the cipher |
| cph_done | input | 1 | Cipher result valid pulse |
| cph_ks | input | 128 | Keystream returned by the cipher |

## Verification
The bench targets configuration writes issued in the middle of a job. A design without the idle lock would move its base address or key partway through, and the scoreboard would then see misplaced writes or the wrong keystream. A start with a zero length, and a repeated start while busy, must produce no memory traffic; a design that ignored either guard would emit writes the scoreboard does not expect. A length that is not a multiple of 16 checks the round-up, and a wrong block count shows up as missing or extra blocks. A region that crosses 0xffff, combined with an all-ones counter, checks both wraps. A counter that stalled at the carry, or an address that did not wrap, would give the wrong keystream or the wrong locations.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   localparam int ADDR_W    = 16;
   localparam int BLK_BYTES = 16;
   localparam int BLK_W     = 8 * BLK_BYTES;
   localparam int IDX_W     = $clog2(BLK_BYTES);
   localparam int NBLK_W    = ADDR_W - IDX_W + 1;
   localparam int WIN_W     = 6;

   localparam logic [WIN_W-1:0] OFS_GO     = 6'h00;
   localparam logic [WIN_W-1:0] OFS_STAT   = 6'h01;
   localparam logic [WIN_W-1:0] OFS_BASE_L = 6'h02;
   localparam logic [WIN_W-1:0] OFS_BASE_H = 6'h03;
   localparam logic [WIN_W-1:0] OFS_LEN_L  = 6'h04;
   localparam logic [WIN_W-1:0] OFS_LEN_H  = 6'h05;
   localparam logic [1:0]       SEL_KEY    = 2'b01;
   localparam logic [1:0]       SEL_CTR    = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_OPER  = 2'd2,
      ST_STORE = 2'd3
   } seq_state_e;
endpackage

// File: rtl/ctr_regfile.sv
module ctr_regfile
   import ctr_pkg::*;
#(
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hff00,
   parameter bit                RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              busy_i,
   input  logic [1:0]        status_i,
   input  logic              ctr_inc_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] len_o,
   output logic [BLK_W-1:0]  key_o,
   output logic [BLK_W-1:0]  ctr_o,
   output logic              go_o
);
   generate
      if (WIN_BASE[WIN_W-1:0] != '0) begin : g_bad_base
         $error("WIN_BASE must be aligned to the register window size");
      end
      if (BLK_BYTES != 16) begin : g_bad_blk
         $error("register map assumes 16-byte key and counter windows");
      end
   endgenerate

   logic              in_win;
   logic [WIN_W-1:0]  ofs;
   logic              wr_hit;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] len_q;
   logic [BLK_W-1:0]  key_q;
   logic [BLK_W-1:0]  ctr_q;
   logic [7:0]        rd_mux;

   assign in_win = (bus_addr[ADDR_W-1:WIN_W] == WIN_BASE[ADDR_W-1:WIN_W]);
   assign ofs    = bus_addr[WIN_W-1:0];
   assign wr_hit = bus_wr && in_win && !busy_i;
   assign go_o   = wr_hit && (ofs == OFS_GO) && bus_wdata[0] && (len_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
      end else if (wr_hit) begin
         case (ofs)
            OFS_BASE_L: base_q[7:0]        <= bus_wdata;
            OFS_BASE_H: base_q[15:8]       <= bus_wdata;
            OFS_LEN_L:  len_q[7:0]         <= bus_wdata;
            OFS_LEN_H:  len_q[15:8]        <= bus_wdata;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (wr_hit && ofs[5:4] == SEL_KEY) begin
         key_q[(BLK_W-1) - 8*int'(ofs[3:0]) -: 8] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr_q <= '0;
      end else if (ctr_inc_i) begin
         ctr_q <= ctr_q + BLK_W'(1);
      end else if (wr_hit && ofs[5:4] == SEL_CTR) begin
         ctr_q[(BLK_W-1) - 8*int'(ofs[3:0]) -: 8] <= bus_wdata;
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      if (ofs[5:4] == SEL_CTR) begin
         rd_mux = ctr_q[(BLK_W-1) - 8*int'(ofs[3:0]) -: 8];
      end else begin
         case (ofs)
            OFS_STAT:   rd_mux = {6'd0, status_i};
            OFS_BASE_L: rd_mux = base_q[7:0];
            OFS_BASE_H: rd_mux = base_q[15:8];
            OFS_LEN_L:  rd_mux = len_q[7:0];
            OFS_LEN_H:  rd_mux = len_q[15:8];
            default:    rd_mux = 8'h00;
         endcase
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                bus_rdata <= 8'h00;
            else if (bus_rd && in_win) bus_rdata <= rd_mux;
            else                       bus_rdata <= 8'h00;
         end
      end else begin : g_rd_comb
         assign bus_rdata = (bus_rd && in_win) ? rd_mux : 8'h00;
      end
   endgenerate

   assign base_o = base_q;
   assign len_o  = len_q;
   assign key_o  = key_q;
   assign ctr_o  = ctr_q;

   // R4: configuration frozen while a job runs
   p_cfg_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(base_q) && $stable(len_q) && $stable(key_q)));

   // R10: each block step adds exactly one to the counter
   p_ctr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_inc_i |=> (ctr_q == BLK_W'($past(ctr_q) + BLK_W'(1))));
endmodule

// File: rtl/ctr_blkbuf.sv
module ctr_blkbuf #(
   parameter int NBYTES = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_en,
   input  logic [$clog2(NBYTES)-1:0] ld_idx,
   input  logic [7:0]                ld_data,
   input  logic                      xor_en,
   input  logic [8*NBYTES-1:0]       ks_i,
   input  logic [$clog2(NBYTES)-1:0] rd_idx,
   output logic [7:0]                rd_data
);
   localparam int IW = $clog2(NBYTES);

   generate
      if (NBYTES < 2 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_n
         $error("NBYTES must be a power of two of at least 2");
      end
   endgenerate

   logic [7:0] lane_q [NBYTES];

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[g] <= 8'h00;
            end else if (ld_en && ld_idx == IW'(g)) begin
               lane_q[g] <= ld_data;
            end else if (xor_en) begin
               lane_q[g] <= lane_q[g] ^ ks_i[8*NBYTES-1-8*g -: 8];
            end
         end
      end
   endgenerate

   assign rd_data = lane_q[rd_idx];
endmodule

// File: rtl/ctr_sequencer.sv
module ctr_sequencer
   import ctr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] len_i,
   output logic              busy_o,
   output logic [1:0]        status_o,
   output logic              ctr_inc_o,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              cph_start,
   input  logic              cph_done,
   input  logic [BLK_W-1:0]  cph_ks
);
   seq_state_e        state_q;
   logic [IDX_W:0]    idx_q;
   logic [ADDR_W-1:0] off_q;
   logic [NBLK_W-1:0] left_q;
   logic              sent_q;
   logic              cap_v_q;
   logic [IDX_W-1:0]  cap_i_q;
   logic [ADDR_W:0]   len_rnd;
   logic [NBLK_W-1:0] nblk;
   logic              last_byte;
   logic              xor_en;

   assign len_rnd   = {1'b0, len_i} + (ADDR_W+1)'(BLK_BYTES - 1);
   assign nblk      = len_rnd[ADDR_W:IDX_W];
   assign last_byte = (idx_q[IDX_W-1:0] == IDX_W'(BLK_BYTES - 1));
   assign xor_en    = (state_q == ST_OPER) && sent_q && cph_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         off_q   <= '0;
         left_q  <= '0;
         sent_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go_i) begin
                  state_q <= ST_LOAD;
                  idx_q   <= '0;
                  off_q   <= '0;
                  left_q  <= nblk;
               end
            end
            ST_LOAD: begin
               if (!idx_q[IDX_W]) begin
                  idx_q <= idx_q + 1'b1;
               end else begin
                  state_q <= ST_OPER;
                  sent_q  <= 1'b0;
               end
            end
            ST_OPER: begin
               if (!sent_q) begin
                  sent_q <= 1'b1;
               end else if (cph_done) begin
                  state_q <= ST_STORE;
                  idx_q   <= '0;
               end
            end
            ST_STORE: begin
               if (last_byte) begin
                  off_q  <= off_q + ADDR_W'(BLK_BYTES);
                  left_q <= left_q - 1'b1;
                  idx_q  <= '0;
                  state_q <= (left_q == NBLK_W'(1)) ? ST_IDLE : ST_LOAD;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_v_q <= 1'b0;
         cap_i_q <= '0;
      end else begin
         cap_v_q <= mem_rd;
         cap_i_q <= idx_q[IDX_W-1:0];
      end
   end

   ctr_blkbuf #(.NBYTES(BLK_BYTES)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (cap_v_q),
      .ld_idx  (cap_i_q),
      .ld_data (mem_rdata),
      .xor_en  (xor_en),
      .ks_i    (cph_ks),
      .rd_idx  (idx_q[IDX_W-1:0]),
      .rd_data (mem_wdata)
   );

   assign mem_rd    = (state_q == ST_LOAD) && !idx_q[IDX_W];
   assign mem_wr    = (state_q == ST_STORE);
   assign mem_addr  = base_i + off_q + ADDR_W'(idx_q[IDX_W-1:0]);
   assign cph_start = (state_q == ST_OPER) && !sent_q;
   assign ctr_inc_o = (state_q == ST_STORE) && last_byte;
   assign busy_o    = (state_q != ST_IDLE);
   assign status_o  = state_q;

   // R6: never read and write memory in one cycle
   p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R6: back-to-back loads walk upward by one byte
   p_load_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R8: back-to-back stores walk upward by one byte
   p_store_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && $past(mem_wr) && !$past(ctr_inc_o)) |->
         (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   // R7: a cipher request is a single-cycle pulse
   p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cph_start |=> !cph_start);

   // R11: no memory traffic the cycle after the final store
   p_quiet_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_inc_o && left_q == NBLK_W'(1)) |=> (!mem_rd && !mem_wr && !busy_o));
endmodule

// File: rtl/ctr_crypt_engine.sv
module ctr_crypt_engine
   import ctr_pkg::*;
#(
   parameter logic [15:0] WIN_BASE = 16'hff00,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [15:0]  bus_addr,
   input  logic [7:0]   bus_wdata,
   input  logic         bus_wr,
   input  logic         bus_rd,
   output logic [7:0]   bus_rdata,
   output logic [15:0]  mem_addr,
   output logic         mem_rd,
   output logic         mem_wr,
   output logic [7:0]   mem_wdata,
   input  logic [7:0]   mem_rdata,
   output logic         cph_start,
   output logic [127:0] cph_ctr,
   output logic [127:0] cph_key,
   input  logic         cph_done,
   input  logic [127:0] cph_ks
);
   logic              busy;
   logic [1:0]        status;
   logic              ctr_inc;
   logic              go;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] len;

   ctr_regfile #(.WIN_BASE(WIN_BASE), .RD_REG(RD_REG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .busy_i    (busy),
      .status_i  (status),
      .ctr_inc_i (ctr_inc),
      .base_o    (base),
      .len_o     (len),
      .key_o     (cph_key),
      .ctr_o     (cph_ctr),
      .go_o      (go)
   );

   ctr_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (go),
      .base_i    (base),
      .len_i     (len),
      .busy_o    (busy),
      .status_o  (status),
      .ctr_inc_o (ctr_inc),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .cph_start (cph_start),
      .cph_done  (cph_done),
      .cph_ks    (cph_ks)
   );

   // R5: a job only begins from idle
   p_go_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);
endmodule

// File: tb/ctr_crypt_engine_tb.sv
module ctr_crypt_engine_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  bus_addr = '0;
   logic [7:0]   bus_wdata = '0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [7:0]   bus_rdata;
   logic [15:0]  mem_addr;
   logic         mem_rd, mem_wr;
   logic [7:0]   mem_wdata;
   logic [7:0]   mem_rdata = '0;
   logic         cph_start;
   logic [127:0] cph_ctr, cph_key;
   logic         cph_done;
   logic [127:0] cph_ks;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [7:0]   mem [1024];
   logic [15:0]  rdq [$];
   logic [23:0]  wrq [$];
   logic [127:0] ctrq [$];
   logic [127:0] exp_key = '0;

   always #4 clk = ~clk;

   ctr_crypt_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .cph_start(cph_start), .cph_ctr(cph_ctr), .cph_key(cph_key),
      .cph_done(cph_done), .cph_ks(cph_ks)
   );

   function automatic logic [127:0] ks_fn(logic [127:0] c, logic [127:0] k);
      return (c ^ {k[63:0], k[127:64]}) + {c[63:0], c[127:64]}
             + 128'h9e3779b97f4a7c15_f39cc0605cedc834;
   endfunction

   // memory model: preset during reset, read data one cycle after request
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3) ^ 8'(i >> 3);
      end else begin
         if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
         if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      end
   end

   // behavioural cipher stand-in
   logic         c_pend = 1'b0;
   logic [2:0]   c_cnt = '0;
   logic [127:0] c_hold = '0;
   always @(posedge clk) begin
      if (cph_start) begin
         c_pend <= 1'b1;
         c_cnt  <= 3'd3;
         c_hold <= ks_fn(cph_ctr, cph_key);
      end else if (c_pend) begin
         if (c_cnt == 3'd1) c_pend <= 1'b0;
         c_cnt <= c_cnt - 1'b1;
      end
   end
   assign cph_done = c_pend && (c_cnt == 3'd1);
   assign cph_ks   = c_hold;

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops scoreboard queues as the design produces traffic
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd) begin
            if (rdq.size() == 0) chk("R5 unexpected load", {112'd0, mem_addr}, 128'hdead);
            else chk("R6 load address", {112'd0, mem_addr}, {112'd0, rdq.pop_front()});
         end
         if (mem_wr) begin
            if (wrq.size() == 0) chk("R5 unexpected store", {104'd0, mem_addr, mem_wdata}, 128'hdead);
            else chk("R8 store addr/data", {104'd0, mem_addr, mem_wdata}, {104'd0, wrq.pop_front()});
         end
         if (cph_start) begin
            if (ctrq.size() == 0) chk("R5 unexpected cipher start", cph_ctr, 128'hdead);
            else chk("R7 cipher counter", cph_ctr, ctrq.pop_front());
            chk("R7 cipher key", cph_key, exp_key);
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_cfg(input logic [15:0] base, input logic [15:0] len,
                          input logic [127:0] key, input logic [127:0] ctr);
      bus_write(16'hff02, base[7:0]);
      bus_write(16'hff03, base[15:8]);
      bus_write(16'hff04, len[7:0]);
      bus_write(16'hff05, len[15:8]);
      for (int i = 0; i < 16; i++) bus_write(16'hff10 + 16'(i), key[127-8*i -: 8]);
      for (int i = 0; i < 16; i++) bus_write(16'hff20 + 16'(i), ctr[127-8*i -: 8]);
      exp_key = key;
   endtask

   task automatic read_ctr(output logic [127:0] c);
      logic [7:0] b;
      for (int i = 0; i < 16; i++) begin
         bus_read(16'hff20 + 16'(i), b);
         c[127-8*i -: 8] = b;
      end
   endtask

   // driver: pushes the expected traffic of one job
   task automatic expect_job(input logic [15:0] base, input logic [15:0] len,
                             input logic [127:0] key, input logic [127:0] ctr0);
      int nb;
      nb = (int'(len) + 15) / 16;
      for (int b = 0; b < nb; b++) begin
         logic [127:0] c, ks;
         c  = ctr0 + 128'(b);
         ks = ks_fn(c, key);
         ctrq.push_back(c);
         for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            a = base + 16'(16 * b + i);
            rdq.push_back(a);
            wrq.push_back({a, mem[a[9:0]] ^ ks[127-8*i -: 8]});
         end
      end
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int k = 0; k < 400; k++) begin
         bus_read(16'hff01, s);
         if (s == 8'd0) break;
      end
   endtask

   localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] CTR_A = 128'hf0f1f2f3f4f5f6f7f8f9fafbfcfdfeff;

   initial begin
      logic [7:0]   d;
      logic [127:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 mem_rd/mem_wr/cph_start idle", {125'd0, mem_rd, mem_wr, cph_start}, 128'd0);
      bus_read(16'hff01, d); chk("R1 status after reset", d, 0);
      bus_read(16'hff02, d); chk("R1 base after reset", d, 0);
      read_ctr(c);           chk("R1 counter after reset", c, 0);

      // R5 zero length start ignored
      bus_write(16'hff02, 8'h00);
      bus_write(16'hff03, 8'h01);
      bus_write(16'hff00, 8'h01);
      bus_read(16'hff01, d); chk("R5 zero-length start stays idle", d, 0);
      repeat (20) @(negedge clk);
      chk("R5 zero-length start no traffic", 128'(rdq.size() + wrq.size()), 0);

      // R2 register map readback
      set_cfg(16'h0100, 16'd16, KEY_A, CTR_A);
      bus_read(16'hff02, d); chk("R2 base low byte", d, 8'h00);
      bus_read(16'hff03, d); chk("R2 base high byte", d, 8'h01);
      bus_read(16'hff04, d); chk("R2 length low byte", d, 8'd16);
      bus_read(16'hff10, d); chk("R2 key not readable", d, 0);
      read_ctr(c);           chk("R2 counter window", c, CTR_A);
      chk("R2 key on cipher port", cph_key, KEY_A);

      // job A: one block with busy-time writes
      expect_job(16'h0100, 16'd16, KEY_A, CTR_A);
      bus_write(16'hff00, 8'h01);
      bus_read(16'hff01, d); chk("R3 status load", d, 1);
      bus_write(16'hff02, 8'h55);
      bus_write(16'hff10, 8'haa);
      bus_write(16'hff04, 8'h60);
      bus_write(16'hff2f, 8'h77);
      bus_write(16'hff00, 8'h01);
      while (!cph_start) @(negedge clk);
      @(negedge clk);
      bus_read(16'hff01, d); chk("R3 status operate", d, 2);
      while (!mem_wr) @(negedge clk);
      bus_read(16'hff01, d); chk("R3 status store", d, 3);
      wait_idle();
      chk("R11 job A fully drained", 128'(rdq.size() + wrq.size() + ctrq.size()), 0);
      bus_read(16'hff02, d); chk("R4 base unchanged by busy write", d, 8'h00);
      bus_read(16'hff04, d); chk("R4 length unchanged by busy write", d, 8'd16);
      chk("R4 key unchanged by busy write", cph_key, KEY_A);
      read_ctr(c);           chk("R10 counter after one block", c, CTR_A + 128'd1);
      repeat (10) @(negedge clk);
      chk("R11 idle after job A", {126'd0, mem_rd, mem_wr}, 0);

      // job B: 40 bytes -> 3 blocks, counter continues
      bus_write(16'hff02, 8'h40);
      bus_write(16'hff04, 8'd40);
      expect_job(16'h0140, 16'd40, KEY_A, CTR_A + 128'd1);
      bus_write(16'hff00, 8'h01);
      wait_idle();
      chk("R9 three blocks drained", 128'(rdq.size() + wrq.size() + ctrq.size()), 0);
      read_ctr(c); chk("R10 counter after three blocks", c, CTR_A + 128'd4);

      // job C: address wrap and counter wrap
      set_cfg(16'hfff0, 16'd17, ~KEY_A, {128{1'b1}});
      bus_read(16'hff05, d); chk("R2 length high byte", d, 8'h00);
      expect_job(16'hfff0, 16'd17, ~KEY_A, {128{1'b1}});
      bus_write(16'hff00, 8'h01);
      wait_idle();
      chk("R9 wrap job drained", 128'(rdq.size() + wrq.size() + ctrq.size()), 0);
      read_ctr(c); chk("R10 counter wraps to one", c, 128'd1);
      chk("R8 plaintext overwritten at 0x0000", {120'd0, mem[0]},
          {120'd0, (8'(0 * 7 + 3) ^ 8'(0)) ^ ks_fn(128'd0, ~KEY_A)[127:120]});

      finish_run();
   end
endmodule